// File: doc/BRIEF.md
# Key-Sequence Register Write Protection Gate

This block guards a peripheral's register file against stray writes. It sits between a simple single-cycle register bus and the peripheral's write strobes. Protected writes pass through only after the host has written two fixed 32-bit key words, in order, to two dedicated key registers. A wrong key value, or any unrelated write between the two keys, drops the gate back to its locked state. Reads are never gated.

The gate forwards each write that it allows to a downstream strobe port, together with its address and data. A bank of three 32-bit scratch words is built in so that the gate's effect can be seen through ordinary reads. A status word and a `locked_o` pin report the gate's state. After reset the gate is locked.

Top module: `regwp_gate`

## Requirements
- R1: After reset, `locked_o` is 1, the status word at 0x74 reads 0, and all three scratch words (0x60, 0x64, 0x68) read 0.
- R2: A write of 0x83E70B13 to 0x6C, followed by a write of 0x95A4F1E0 to 0x70 with no other write between them, unlocks the gate. `locked_o` reads 0 from the cycle after the second write, and status bit 0 (writes allowed) reads 1.
- R3: While the gate is locked, which includes the state where only the first key has been accepted, a write to any address other than 0x6C, 0x70 and 0x74 raises no `ds_wr_o` and leaves the scratch words unchanged.
- R4: While the gate is unlocked, a write to any address other than 0x6C, 0x70 and 0x74 raises `ds_wr_o` in the same cycle, with `ds_addr_o` and `ds_wdata_o` equal to the bus address and data. A write to a scratch word sets that word to the written data.
- R5: Writing 0x95A4F1E0 to 0x70 while the gate is fully locked, with no first key accepted, leaves it locked.
- R6: Writing any value other than 0x83E70B13 to 0x6C, or any value other than 0x95A4F1E0 to 0x70, locks the gate from any state. This includes writing zero.
- R7: After the first key has been accepted, any write to an address other than 0x6C and 0x70 cancels the sequence. The gate returns to fully locked, so a following second key does not unlock it. Writing the first key again keeps the first-key state.
- R8: Reads are never blocked. Scratch words read back in every state. The key registers and unmapped addresses read 0. The status word at 0x74 has bit 0 set to 1 when unlocked and bit 1 set to 1 when only the first key has been accepted, with all other bits 0.
- R9: Writes to 0x6C, 0x70 and 0x74 never raise `ds_wr_o`. A write to 0x74 while unlocked leaves the gate unlocked.
- R10: While the gate is unlocked, writing the second key again keeps it unlocked. Writing the first key restarts the sequence: the gate becomes locked with status bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Bus transfer present this cycle |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 8 | Byte address of the transfer |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, available in the same cycle |
| ds_wr_o | output | 1 | Write strobe allowed through to the protected registers |
| ds_addr_o | output | 8 | Address for the downstream write |
| ds_wdata_o | output | 32 | Data for the downstream write |
| locked_o | output | 1 | 1 while protected writes are blocked |

## Verification
The assertions assume that the bus inputs hold known values and change only away from the rising clock edge. They also assume that reset is held for several cycles, so the first sampled past values come from a reset state. The bench meets these assumptions by driving every transfer on the falling edge with word-aligned addresses. It returns the bus to idle after each transfer and holds reset for five cycles. Idle cycles between the two key writes are allowed by design, so the idle gaps the bench inserts never interfere with the cancellation rule under test.

// File: rtl/regwp_pkg.sv
package regwp_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int SCR_WORDS = 3;
    localparam int SCR_IDX_W = (SCR_WORDS > 1) ? $clog2(SCR_WORDS) : 1;

    localparam logic [ADDR_W-1:0] SCR_BASE   = 8'h60;
    localparam logic [ADDR_W-1:0] KICK0_OFF  = 8'h6C;
    localparam logic [ADDR_W-1:0] KICK1_OFF  = 8'h70;
    localparam logic [ADDR_W-1:0] STATUS_OFF = 8'h74;

    localparam logic [DATA_W-1:0] KEY0_DEF = 32'h83E7_0B13;
    localparam logic [DATA_W-1:0] KEY1_DEF = 32'h95A4_F1E0;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_HALF   = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic                 kick0;
        logic                 kick1;
        logic                 status;
        logic                 scratch;
        logic [SCR_IDX_W-1:0] scr_idx;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t         d;
        logic [ADDR_W-1:0] off;
        d         = '0;
        off       = a - SCR_BASE;
        d.kick0   = (a == KICK0_OFF);
        d.kick1   = (a == KICK1_OFF);
        d.status  = (a == STATUS_OFF);
        d.scratch = (int'(a) >= int'(SCR_BASE)) &&
                    (int'(a) < int'(SCR_BASE) + SCR_WORDS * 4) &&
                    (a[1:0] == 2'b00);
        d.scr_idx = off[SCR_IDX_W+1:2];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input gate_state_e s);
        return {{(DATA_W-2){1'b0}}, (s == GATE_HALF), (s == GATE_OPEN)};
    endfunction

endpackage

// File: rtl/regwp_decode.sv
module regwp_decode
    import regwp_pkg::*;
(
    input  bus_req_t  req_i,
    input  logic      unlocked_i,
    output addr_dec_t dec_o,
    output logic      wr_any_o,
    output logic      ds_wr_o
);

    logic control_hit;

    always_comb begin
        dec_o       = decode_addr(req_i.addr);
        wr_any_o    = req_i.valid & req_i.write;
        control_hit = dec_o.kick0 | dec_o.kick1 | dec_o.status;
        ds_wr_o     = wr_any_o & unlocked_i & ~control_hit;
    end

endmodule

// File: rtl/regwp_unlock_fsm.sv
module regwp_unlock_fsm
    import regwp_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY0 = KEY0_DEF,
    parameter logic [DATA_W-1:0] KEY1 = KEY1_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_any_i,
    input  addr_dec_t         dec_i,
    input  logic [DATA_W-1:0] wdata_i,
    output gate_state_e       state_o
);

    gate_state_e state_d;
    logic        wr_k0;
    logic        wr_k1;
    logic        wr_other;

    always_comb begin
        wr_k0    = wr_any_i & dec_i.kick0;
        wr_k1    = wr_any_i & dec_i.kick1;
        wr_other = wr_any_i & ~dec_i.kick0 & ~dec_i.kick1;
        state_d  = state_o;
        if (wr_k0) begin
            state_d = (wdata_i == KEY0) ? GATE_HALF : GATE_LOCKED;
        end else if (wr_k1) begin
            if ((wdata_i == KEY1) && (state_o != GATE_LOCKED))
                state_d = GATE_OPEN;
            else
                state_d = GATE_LOCKED;
        end else if (wr_other && (state_o == GATE_HALF)) begin
            state_d = GATE_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_o <= GATE_LOCKED;
        else     state_o <= state_d;
    end

    p_open_from_half_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == GATE_OPEN && $past(state_o) != GATE_OPEN) |-> $past(state_o) == GATE_HALF);

    p_lone_key1_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_k1 && state_o == GATE_LOCKED) |=> state_o == GATE_LOCKED);

    p_bad_key0_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_k0 && wdata_i != KEY0) |=> state_o == GATE_LOCKED);

    p_bad_key1_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_k1 && wdata_i != KEY1) |=> state_o == GATE_LOCKED);

    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_other && state_o == GATE_HALF) |=> state_o == GATE_LOCKED);

    p_key1_holds_open_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_k1 && wdata_i == KEY1 && state_o == GATE_OPEN) |=> state_o == GATE_OPEN);

endmodule

// File: rtl/regwp_scratch.sv
module regwp_scratch
    import regwp_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_i,
    input  logic [SCR_IDX_W-1:0]                idx_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [SCR_WORDS-1:0][DATA_W-1:0]    words_o
);

    for (genvar g = 0; g < SCR_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words_o[g] <= '0;
            else if (wr_i && (idx_i == SCR_IDX_W'(g)))
                words_o[g] <= wdata_i;
        end
    end

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && int'(idx_i) < SCR_WORDS) |=> words_o[$past(idx_i)] == $past(wdata_i));

endmodule

// File: rtl/regwp_gate.sv
module regwp_gate
    import regwp_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY0 = KEY0_DEF,
    parameter logic [DATA_W-1:0] KEY1 = KEY1_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              ds_wr_o,
    output logic [ADDR_W-1:0] ds_addr_o,
    output logic [DATA_W-1:0] ds_wdata_o,
    output logic              locked_o
);

    bus_req_t                         req;
    addr_dec_t                        dec;
    logic                             wr_any;
    gate_state_e                      state;
    logic [SCR_WORDS-1:0][DATA_W-1:0] scr_words;

    assign req = '{valid: bus_valid_i, write: bus_write_i,
                   addr: bus_addr_i, wdata: bus_wdata_i};

    regwp_decode u_decode (
        .req_i      (req),
        .unlocked_i (state == GATE_OPEN),
        .dec_o      (dec),
        .wr_any_o   (wr_any),
        .ds_wr_o    (ds_wr_o)
    );

    regwp_unlock_fsm #(.KEY0(KEY0), .KEY1(KEY1)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_any_i (wr_any),
        .dec_i    (dec),
        .wdata_i  (bus_wdata_i),
        .state_o  (state)
    );

    regwp_scratch u_scratch (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ds_wr_o & dec.scratch),
        .idx_i   (dec.scr_idx),
        .wdata_i (bus_wdata_i),
        .words_o (scr_words)
    );

    assign ds_addr_o  = bus_addr_i;
    assign ds_wdata_o = bus_wdata_i;
    assign locked_o   = (state != GATE_OPEN);

    always_comb begin
        bus_rdata_o = '0;
        if (dec.scratch && int'(dec.scr_idx) < SCR_WORDS)
            bus_rdata_o = scr_words[dec.scr_idx];
        else if (dec.status)
            bus_rdata_o = status_word(state);
    end

    p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (locked_o && scr_words == '0));

    p_scr_hold_locked_r3: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> $stable(scr_words));

    p_ctrl_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_i && bus_write_i &&
         (bus_addr_i == KICK0_OFF || bus_addr_i == KICK1_OFF || bus_addr_i == STATUS_OFF))
        |-> !ds_wr_o);

endmodule

// File: tb/regwp_gate_tb_top.sv
module regwp_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;
    localparam logic [7:0]  A_K0 = 8'h6C;
    localparam logic [7:0]  A_K1 = 8'h70;
    localparam logic [7:0]  A_ST = 8'h74;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ds_wr;
    logic [7:0]  ds_addr;
    logic [31:0] ds_wdata;
    logic        locked;

    int n_checks = 0;
    int n_fail   = 0;
    int m_st     = 0;
    logic [31:0] m_scr [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    regwp_gate dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ds_wr_o     (ds_wr),
        .ds_addr_o   (ds_addr),
        .ds_wdata_o  (ds_wdata),
        .locked_o    (locked)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_scr(input logic [7:0] a);
        return (a == 8'h60) || (a == 8'h64) || (a == 8'h68);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (is_scr(a)) return m_scr[(a - 8'h60) >> 2];
        if (a == A_ST) return {30'b0, (m_st == 1), (m_st == 2)};
        return 32'h0;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        bit exp_strobe;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        exp_strobe = (m_st == 2) && (a != A_K0) && (a != A_K1) && (a != A_ST);
        check({tag, " strobe"}, {31'b0, ds_wr}, {31'b0, exp_strobe});
        if (exp_strobe) begin
            check({tag, " ds_addr"}, {24'b0, ds_addr}, {24'b0, a});
            check({tag, " ds_wdata"}, ds_wdata, d);
        end
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
        if (a == A_K0)      m_st = (d == K0) ? 1 : 0;
        else if (a == A_K1) m_st = (d == K1 && m_st != 0) ? 2 : 0;
        else begin
            if (m_st == 2 && is_scr(a)) m_scr[(a - 8'h60) >> 2] = d;
            if (m_st == 1) m_st = 0;
        end
        check({tag, " locked"}, {31'b0, locked}, {31'b0, (m_st != 2)});
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic read_all_map(input string tag);
        for (int i = 0; i < 32; i++) rd(8'(i * 4), tag);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) m_scr[i] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 locked after reset", {31'b0, locked}, 32'h1);
        rd(A_ST, "R1 status after reset");
        for (int i = 0; i < 3; i++) rd(8'(8'h60 + i * 4), "R1 scratch after reset");

        // R3 locked writes dropped
        for (int i = 0; i < 3; i++) wr(8'(8'h60 + i * 4), 32'hDEAD_0000 + i, "R3 locked scratch write");
        wr(8'h10, 32'h1234_5678, "R3 locked other write");
        for (int i = 0; i < 3; i++) rd(8'(8'h60 + i * 4), "R3 scratch unchanged");

        // R5 lone second key
        wr(A_K1, K1, "R5 key1 alone");
        rd(A_ST, "R5 status");

        // R2 unlock, R3 half state drops writes
        wr(A_K0, K0, "R2 key0");
        rd(A_ST, "R2 half status");
        wr(A_K0, K0, "R7 key0 repeat keeps half");
        wr(A_K1, K1, "R2 key1");
        rd(A_ST, "R2 open status");

        // R4 open writes
        for (int i = 0; i < 3; i++) wr(8'(8'h60 + i * 4), 32'hC0DE_0100 * (i + 1), "R4 open scratch write");
        for (int i = 0; i < 3; i++) rd(8'(8'h60 + i * 4), "R4 scratch readback");
        wr(8'h24, 32'hABCD_EF01, "R4 open other write");

        // R9 status write and kick/status strobes
        wr(A_ST, 32'hFFFF_FFFF, "R9 status write open");
        rd(A_ST, "R9 status after write");

        // R10 keys while open
        wr(A_K1, K1, "R10 key1 while open");
        wr(A_K0, K0, "R10 key0 while open");
        rd(A_ST, "R10 restart status");
        wr(A_K1, K1, "R10 finish restart");

        // R6 relock paths
        wr(A_K0, 32'h0, "R6 zero kick0");
        rd(A_ST, "R6 status");
        wr(A_K0, K0, "R6 prep"); wr(A_K1, K1, "R6 prep");
        wr(A_K1, 32'h0, "R6 zero kick1");
        wr(A_K0, K0, "R6 prep"); wr(A_K1, K1, "R6 prep");
        wr(A_K0, K0 ^ 32'h1, "R6 near key0");
        wr(A_K0, K0, "R6 prep"); wr(A_K1, K1 ^ 32'h8000_0000, "R6 near key1 from half");
        wr(A_K0, K0, "R6 prep"); wr(A_K1, K1, "R6 prep");
        wr(A_K1, K1 ^ 32'h1, "R6 near key1 from open");

        // R7 abort by intervening write
        wr(A_K0, K0, "R7 key0");
        wr(8'h64, 32'h5555_AAAA, "R7 intervening write");
        wr(A_K1, K1, "R7 key1 after abort");
        rd(8'h64, "R7 scratch unchanged");
        wr(A_K0, K0, "R7 key0");
        wr(A_ST, 32'h0, "R7 status write aborts");
        wr(A_K1, K1, "R7 key1 after status abort");
        wr(A_K0, K0, "R7 key0");
        rd(8'h60, "R7 read does not abort");
        wr(A_K1, K1, "R7 key1 after read");

        // sweep: open writes to all non-key addresses, then read whole map (R4, R8)
        for (int i = 0; i < 32; i++) begin
            if (8'(i * 4) != A_K0 && 8'(i * 4) != A_K1)
                wr(8'(i * 4), 32'hA500_0000 | i, "R4 sweep open write");
        end
        read_all_map("R8 sweep read open");

        // relock, sweep locked writes, read whole map (R3, R8)
        wr(A_K0, 32'h0, "R6 relock"); wr(A_K1, 32'h0, "R6 relock");
        for (int i = 0; i < 32; i++) begin
            if (8'(i * 4) != A_K0 && 8'(i * 4) != A_K1)
                wr(8'(i * 4), 32'h5A00_0000 | i, "R3 sweep locked write");
        end
        read_all_map("R8 sweep read locked");

        wr(A_K0, K0, "R8 half");
        read_all_map("R8 sweep read half");

        finish_run();
    end

endmodule